// File: doc/BRIEF.md
# Flash Program/Erase Operation Sequencer

This block runs the long, timed operations of an embedded flash array: programming a small burst of words, erasing one page, erasing the whole array, and recalling the trim code. A register bank hands it three things. The first is a one-cycle start pulse with a two-bit command. The second is the address register. The third is a set of three timing words. The block then drives the array's strobe interface for cycle counts taken from those timing words. It holds `busy_o` high for the whole operation and advances the address once the operation is over.

Program data is collected first in a 32-byte staging buffer. Each accepted write beat lands at the current byte index, and the index then grows by the bus width. The buffer takes beats over a valid/ready interface. A beat transfers on a clock edge where `pb_valid_i` and `pb_ready_o` are both high. Ready is withdrawn while an operation runs, and also when one more beat would carry the burst past a 32-byte aligned boundary measured from the address register. A producer that keeps valid high simply stalls. The address register advances by the buffered byte count after every operation, so a run of sequential bursts needs the address written only once, as long as the index is cleared before each fill.

Timing fields: word 0 bits 31:16 give the post-strobe hold count. Word 1 bits 23:0 give the erase strobe count. Word 2 bits 15:0 give the per-word program strobe count, and word 2 bits 23:16 give the recall strobe count. Bits not listed are carried but unused.

Top module: `flash_op_seq`

## Requirements
- R1: After reset `busy_o`, `addr_o`, `pb_idx_o`, `mac_addr_o`, `mac_wdata_o` and all four strobes are zero.
- R2: A beat accepted (valid and ready high at an edge) is stored as buffer word `pb_idx_o/4`, and `pb_idx_o` rises by 4 one cycle later. `pb_clr_i` high while idle sets the index to zero and takes priority over a beat in the same cycle.
- R3: `pb_ready_o` is high only when idle and `addr_o[4:0] + pb_idx_o + 4 <= 32`, so the index never exceeds 32 and a burst never crosses a 32-byte aligned boundary.
- R4: Command 00 (program) with a nonzero index drives `mac_prog_o` for max(word2[15:0],1) cycles per buffered word, starting the cycle after the start edge. During word i, `mac_addr_o` = `addr_o + 4*i` and `mac_wdata_o` = buffer word i.
- R5: Program and both erases are followed by word0[31:16] hold cycles with no strobe, then by one final busy cycle. `busy_o` is high from the cycle after the start edge through that final cycle.
- R6: Command 01 (page erase) drives `mac_erase_o` for max(word1[23:0],1) cycles with `mac_addr_o` equal to `addr_o` with bits 11:0 cleared (4096-byte page).
- R7: Command 10 (mass erase) drives `mac_erase_all_o` for max(word1[23:0],1) cycles with `mac_addr_o` zero.
- R8: Command 11 (recall) drives `mac_recall_o` for max(word2[23:16],1) cycles, followed directly by the final busy cycle with no hold.
- R9: On the edge that ends the final busy cycle, `addr_o` increases by `pb_idx_o` (modulo the address width), and the index keeps its value.
- R10: While busy, start pulses, address writes, index clears and buffer beats have no effect. At most one strobe is high at any time, and none is high while idle.
- R11: A program command with index zero gives exactly one busy cycle with no strobe, and the address is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle operation start pulse |
| cmd_i | input | 2 | 00 program, 01 page erase, 10 mass erase, 11 recall |
| addr_we_i | input | 1 | Load address register (idle only) |
| addr_wdata_i | input | ADDR_W | New address value |
| timing0_i | input | 32 | Timing word 0 (hold count in 31:16) |
| timing1_i | input | 32 | Timing word 1 (erase count in 23:0) |
| timing2_i | input | 32 | Timing word 2 (program count 15:0, recall count 23:16) |
| pb_clr_i | input | 1 | Clear buffer index (idle only) |
| pb_valid_i | input | 1 | Buffer beat valid |
| pb_ready_o | output | 1 | Buffer can accept a beat |
| pb_data_i | input | 8*BUS_BYTES | Buffer beat data |
| busy_o | output | 1 | Operation in progress |
| addr_o | output | ADDR_W | Address register |
| pb_idx_o | output | $clog2(PB_BYTES)+1 | Buffer byte index |
| mac_addr_o | output | ADDR_W | Array address during a strobe |
| mac_wdata_o | output | 8*BUS_BYTES | Array write data during a program strobe |
| mac_prog_o | output | 1 | Program strobe |
| mac_erase_o | output | 1 | Page erase strobe |
| mac_erase_all_o | output | 1 | Mass erase strobe |
| mac_recall_o | output | 1 | Trim recall strobe |

## Verification
`busy_o` and the first strobe appear in the cycle after the edge that samples the start pulse. Each strobe phase then lasts exactly its programmed count. `pb_idx_o` moves one cycle after an accepted beat. `addr_o` moves on the edge that ends the final busy cycle, which is the same edge where `busy_o` falls. The bench holds a behavioural model that queues the expected output of every future cycle of an operation when the start is sampled. All outputs are compared against that queue at every falling edge, so every register delay is accounted for without picking sample points by hand. Directed checks at the end of each operation pin down the expected address and index values.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [1:0] {
    OP_PROG      = 2'b00,
    OP_PG_ERASE  = 2'b01,
    OP_ALL_ERASE = 2'b10,
    OP_RECALL    = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_STROBE,
    ST_HOLD,
    ST_DONE
  } seq_st_e;

  localparam int CNT_W = 24;

  typedef struct packed {
    logic [15:0] hold;
    logic [23:0] erase;
    logic [15:0] prog;
    logic [7:0]  recall;
  } tim_t;

  // field positions are fixed by the register bank that fills these words
  function automatic tim_t decode_timing(input logic [31:0] w0,
                                         input logic [31:0] w1,
                                         input logic [31:0] w2);
    tim_t t;
    t.hold   = w0[31:16];
    t.erase  = w1[23:0];
    t.prog   = w2[15:0];
    t.recall = w2[23:16];
    return t;
  endfunction

endpackage

// File: rtl/flash_pbuf.sv
module flash_pbuf #(
  parameter  int BUS_BYTES = 4,
  parameter  int PB_BYTES  = 32,
  localparam int BUS_W     = 8 * BUS_BYTES,
  localparam int PB_WORDS  = PB_BYTES / BUS_BYTES,
  localparam int OFF_W     = $clog2(PB_BYTES),
  localparam int IDX_W     = OFF_W + 1,
  localparam int WORD_W    = (PB_WORDS > 1) ? $clog2(PB_WORDS) : 1,
  localparam int LANE_SH   = $clog2(BUS_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic [OFF_W-1:0]  addr_off,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [BUS_W-1:0]  wr_data,
  input  logic              clr,
  input  logic [WORD_W-1:0] rd_word,
  output logic [BUS_W-1:0]  rd_data,
  output logic [IDX_W-1:0]  idx
);

  logic [IDX_W-1:0]  idx_q;
  logic [IDX_W:0]    fill_end;
  logic [WORD_W-1:0] wr_word;
  logic              wr_fire;
  logic              clr_ok;
  logic [BUS_W-1:0]  words [PB_WORDS];

  // a beat is allowed only if it stays inside the current aligned window
  assign fill_end = {1'b0, idx_q} + (IDX_W+1)'(addr_off) + (IDX_W+1)'(BUS_BYTES);
  assign wr_ready = !busy && (fill_end <= (IDX_W+1)'(PB_BYTES));
  assign clr_ok   = clr && !busy;
  assign wr_fire  = wr_valid && wr_ready && !clr_ok;
  assign wr_word  = WORD_W'(idx_q >> LANE_SH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (clr_ok) begin
      idx_q <= '0;
    end else if (wr_fire) begin
      idx_q <= idx_q + IDX_W'(BUS_BYTES);
    end
  end

  for (genvar w = 0; w < PB_WORDS; w++) begin : g_word
    logic [BUS_W-1:0] word_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        word_q <= '0;
      end else if (wr_fire && (wr_word == WORD_W'(w))) begin
        word_q <= wr_data;
      end
    end
    assign words[w] = word_q;
  end

  assign rd_data = words[rd_word];
  assign idx     = idx_q;

endmodule

// File: rtl/flash_cycle_timer.sv
module flash_cycle_timer #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // a loaded count of zero still yields one cycle
  assign last = (cnt_q <= CNT_W'(1));

endmodule

// File: rtl/flash_op_ctrl.sv
module flash_op_ctrl
  import flash_seq_pkg::*;
#(
  parameter  int ADDR_W     = 20,
  parameter  int BUS_BYTES  = 4,
  parameter  int PB_BYTES   = 32,
  parameter  int PAGE_BYTES = 4096,
  localparam int PB_WORDS   = PB_BYTES / BUS_BYTES,
  localparam int IDX_W      = $clog2(PB_BYTES) + 1,
  localparam int WORD_W     = (PB_WORDS > 1) ? $clog2(PB_WORDS) : 1,
  localparam int LANE_SH    = $clog2(BUS_BYTES),
  localparam int PAGE_SH    = $clog2(PAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        cmd,
  input  logic              addr_we,
  input  logic [ADDR_W-1:0] addr_wdata,
  input  tim_t              tim,
  input  logic [IDX_W-1:0]  pb_idx,
  output logic [WORD_W-1:0] word,
  output logic              tmr_load,
  output logic [CNT_W-1:0]  tmr_val,
  input  logic              tmr_last,
  output logic              busy,
  output logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] mac_addr,
  output logic              mac_prog,
  output logic              mac_erase,
  output logic              mac_erase_all,
  output logic              mac_recall
);

  seq_st_e           st_q, st_d;
  op_e               op_q, cmd_op;
  logic [WORD_W-1:0] word_q, word_d;
  logic [ADDR_W-1:0] addr_q;
  logic [IDX_W-1:0]  n_words;
  logic              last_word;
  logic              strobing;

  function automatic logic [CNT_W-1:0] strobe_len(input op_e o, input tim_t t);
    case (o)
      OP_PROG:                  return CNT_W'(t.prog);
      OP_PG_ERASE, OP_ALL_ERASE: return t.erase;
      default:                  return CNT_W'(t.recall);
    endcase
  endfunction

  assign cmd_op    = op_e'(cmd);
  assign n_words   = pb_idx >> LANE_SH;
  assign last_word = (IDX_W'(word_q) + IDX_W'(1)) == n_words;

  always_comb begin
    st_d     = st_q;
    word_d   = word_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          word_d = '0;
          if (cmd_op == OP_PROG && pb_idx == '0) begin
            st_d = ST_DONE;
          end else begin
            st_d     = ST_STROBE;
            tmr_load = 1'b1;
            tmr_val  = strobe_len(cmd_op, tim);
          end
        end
      end
      ST_STROBE: begin
        if (tmr_last) begin
          if (op_q == OP_PROG && !last_word) begin
            word_d   = word_q + 1'b1;
            tmr_load = 1'b1;
            tmr_val  = strobe_len(OP_PROG, tim);
          end else if (op_q != OP_RECALL && tim.hold != '0) begin
            st_d     = ST_HOLD;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(tim.hold);
          end else begin
            st_d = ST_DONE;
          end
        end
      end
      ST_HOLD: begin
        if (tmr_last) st_d = ST_DONE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      op_q   <= OP_PROG;
      word_q <= '0;
      addr_q <= '0;
    end else begin
      st_q   <= st_d;
      word_q <= word_d;
      if (st_q == ST_IDLE && start) op_q <= cmd_op;
      if (st_q == ST_DONE) begin
        addr_q <= addr_q + ADDR_W'(pb_idx);
      end else if (st_q == ST_IDLE && addr_we) begin
        addr_q <= addr_wdata;
      end
    end
  end

  assign strobing      = (st_q == ST_STROBE);
  assign mac_prog      = strobing && (op_q == OP_PROG);
  assign mac_erase     = strobing && (op_q == OP_PG_ERASE);
  assign mac_erase_all = strobing && (op_q == OP_ALL_ERASE);
  assign mac_recall    = strobing && (op_q == OP_RECALL);

  always_comb begin
    mac_addr = '0;
    if (mac_prog) begin
      mac_addr = addr_q + (ADDR_W'(word_q) << LANE_SH);
    end else if (mac_erase) begin
      mac_addr = {addr_q[ADDR_W-1:PAGE_SH], {PAGE_SH{1'b0}}};
    end
  end

  assign busy = (st_q != ST_IDLE);
  assign addr = addr_q;
  assign word = word_q;

endmodule

// File: rtl/flash_op_seq.sv
module flash_op_seq
  import flash_seq_pkg::*;
#(
  parameter  int ADDR_W     = 20,
  parameter  int BUS_BYTES  = 4,
  parameter  int PB_BYTES   = 32,
  parameter  int PAGE_BYTES = 4096,
  localparam int BUS_W      = 8 * BUS_BYTES,
  localparam int OFF_W      = $clog2(PB_BYTES),
  localparam int IDX_W      = OFF_W + 1,
  localparam int PB_WORDS   = PB_BYTES / BUS_BYTES,
  localparam int WORD_W     = (PB_WORDS > 1) ? $clog2(PB_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [1:0]        cmd_i,
  input  logic              addr_we_i,
  input  logic [ADDR_W-1:0] addr_wdata_i,
  input  logic [31:0]       timing0_i,
  input  logic [31:0]       timing1_i,
  input  logic [31:0]       timing2_i,
  input  logic              pb_clr_i,
  input  logic              pb_valid_i,
  output logic              pb_ready_o,
  input  logic [BUS_W-1:0]  pb_data_i,
  output logic              busy_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [IDX_W-1:0]  pb_idx_o,
  output logic [ADDR_W-1:0] mac_addr_o,
  output logic [BUS_W-1:0]  mac_wdata_o,
  output logic              mac_prog_o,
  output logic              mac_erase_o,
  output logic              mac_erase_all_o,
  output logic              mac_recall_o
);

  tim_t              tim;
  logic [WORD_W-1:0] word;
  logic [BUS_W-1:0]  rd_data;
  logic              tmr_load;
  logic [CNT_W-1:0]  tmr_val;
  logic              tmr_last;

  assign tim = decode_timing(timing0_i, timing1_i, timing2_i);

  flash_pbuf #(
    .BUS_BYTES (BUS_BYTES),
    .PB_BYTES  (PB_BYTES)
  ) u_pbuf (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy_o),
    .addr_off (addr_o[OFF_W-1:0]),
    .wr_valid (pb_valid_i),
    .wr_ready (pb_ready_o),
    .wr_data  (pb_data_i),
    .clr      (pb_clr_i),
    .rd_word  (word),
    .rd_data  (rd_data),
    .idx      (pb_idx_o)
  );

  flash_cycle_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .last     (tmr_last)
  );

  flash_op_ctrl #(
    .ADDR_W     (ADDR_W),
    .BUS_BYTES  (BUS_BYTES),
    .PB_BYTES   (PB_BYTES),
    .PAGE_BYTES (PAGE_BYTES)
  ) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start_i),
    .cmd           (cmd_i),
    .addr_we       (addr_we_i),
    .addr_wdata    (addr_wdata_i),
    .tim           (tim),
    .pb_idx        (pb_idx_o),
    .word          (word),
    .tmr_load      (tmr_load),
    .tmr_val       (tmr_val),
    .tmr_last      (tmr_last),
    .busy          (busy_o),
    .addr          (addr_o),
    .mac_addr      (mac_addr_o),
    .mac_prog      (mac_prog_o),
    .mac_erase     (mac_erase_o),
    .mac_erase_all (mac_erase_all_o),
    .mac_recall    (mac_recall_o)
  );

  assign mac_wdata_o = mac_prog_o ? rd_data : '0;

endmodule

// File: rtl/flash_op_seq_chk.sv
module flash_op_seq_chk #(
  parameter int ADDR_W   = 20,
  parameter int IDX_W    = 6,
  parameter int PB_BYTES = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic [1:0]        cmd_i,
  input logic              busy_o,
  input logic              pb_ready_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic [IDX_W-1:0]  pb_idx_o,
  input logic              mac_prog_o,
  input logic              mac_erase_o,
  input logic              mac_erase_all_o,
  input logic              mac_recall_o
);

  logic [3:0] strobes;
  assign strobes = {mac_prog_o, mac_erase_o, mac_erase_all_o, mac_recall_o};

  p_reset_idle_r1: assert property (@(posedge clk) !rst_n |=> !busy_o && strobes == 4'b0);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pb_idx_o <= IDX_W'(PB_BYTES));

  p_ready_blocked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !pb_ready_o);

  p_start_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && !busy_o |=> busy_o);

  p_idx_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> $stable(pb_idx_o));

  p_addr_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && $past(busy_o) |-> $stable(addr_o));

  p_one_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strobes));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> strobes == 4'b0);

  p_empty_prog_r11: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && !busy_o && cmd_i == 2'b00 && pb_idx_o == '0 |=> busy_o && strobes == 4'b0);

endmodule

bind flash_op_seq flash_op_seq_chk #(
  .ADDR_W   (ADDR_W),
  .IDX_W    (IDX_W),
  .PB_BYTES (PB_BYTES)
) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .start_i         (start_i),
  .cmd_i           (cmd_i),
  .busy_o          (busy_o),
  .pb_ready_o      (pb_ready_o),
  .addr_o          (addr_o),
  .pb_idx_o        (pb_idx_o),
  .mac_prog_o      (mac_prog_o),
  .mac_erase_o     (mac_erase_o),
  .mac_erase_all_o (mac_erase_all_o),
  .mac_recall_o    (mac_recall_o)
);

// File: tb/flash_op_seq_tb.sv
module flash_op_seq_tb;

  localparam int ADDR_W = 20;
  localparam int AMASK  = (1 << ADDR_W) - 1;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst_n = 1'b0;
  logic              start_i = 1'b0;
  logic [1:0]        cmd_i = 2'b00;
  logic              addr_we_i = 1'b0;
  logic [ADDR_W-1:0] addr_wdata_i = '0;
  logic [31:0]       timing0_i = '0, timing1_i = '0, timing2_i = '0;
  logic              pb_clr_i = 1'b0, pb_valid_i = 1'b0;
  logic [31:0]       pb_data_i = '0;
  logic              pb_ready_o, busy_o;
  logic [ADDR_W-1:0] addr_o, mac_addr_o;
  logic [5:0]        pb_idx_o;
  logic [31:0]       mac_wdata_o;
  logic              mac_prog_o, mac_erase_o, mac_erase_all_o, mac_recall_o;

  flash_op_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmd_i(cmd_i),
    .addr_we_i(addr_we_i), .addr_wdata_i(addr_wdata_i),
    .timing0_i(timing0_i), .timing1_i(timing1_i), .timing2_i(timing2_i),
    .pb_clr_i(pb_clr_i), .pb_valid_i(pb_valid_i), .pb_ready_o(pb_ready_o),
    .pb_data_i(pb_data_i), .busy_o(busy_o), .addr_o(addr_o), .pb_idx_o(pb_idx_o),
    .mac_addr_o(mac_addr_o), .mac_wdata_o(mac_wdata_o), .mac_prog_o(mac_prog_o),
    .mac_erase_o(mac_erase_o), .mac_erase_all_o(mac_erase_all_o),
    .mac_recall_o(mac_recall_o)
  );

  typedef struct {
    bit          p, e, a, r, last;
    int unsigned ma, wd;
  } ent_t;

  ent_t        q[$];
  int unsigned m_mem[8];
  int unsigned m_addr, m_idx;
  int          n_chk = 0, n_fail = 0;
  bit          cmp_en = 1'b0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic bit m_ready();
    return (q.size() == 0) && ((m_addr & 31) + m_idx + 4 <= 32);
  endfunction

  function automatic int max1(input int v);
    return (v < 1) ? 1 : v;
  endfunction

  function automatic void build(input logic [1:0] c);
    ent_t e;
    int   len, hold;
    hold = int'(timing0_i[31:16]);
    if (c == 2'b00) begin
      len = max1(int'(timing2_i[15:0]));
      for (int w = 0; w < int'(m_idx / 4); w++)
        for (int k = 0; k < len; k++) begin
          e = '{default: 0};
          e.p = 1; e.ma = (m_addr + 4 * w) & AMASK; e.wd = m_mem[w];
          q.push_back(e);
        end
    end else if (c == 2'b11) begin
      len = max1(int'(timing2_i[23:16]));
      for (int k = 0; k < len; k++) begin
        e = '{default: 0}; e.r = 1; q.push_back(e);
      end
    end else begin
      len = max1(int'(timing1_i[23:0]));
      for (int k = 0; k < len; k++) begin
        e = '{default: 0};
        if (c == 2'b01) begin e.e = 1; e.ma = m_addr & 32'hFF000; end
        else e.a = 1;
        q.push_back(e);
      end
    end
    if (!(c == 2'b00 && m_idx == 0) && c != 2'b11)
      for (int k = 0; k < hold; k++) begin
        e = '{default: 0}; q.push_back(e);
      end
    e = '{default: 0}; e.last = 1; q.push_back(e);
  endfunction

  // behavioural reference, advanced on each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); m_addr = 0; m_idx = 0;
      for (int i = 0; i < 8; i++) m_mem[i] = 0;
    end else if (q.size() != 0) begin
      ent_t c;
      c = q.pop_front();
      if (c.last) m_addr = (m_addr + m_idx) & AMASK;
    end else if (start_i) begin
      build(cmd_i);
    end else begin
      bit rdy;
      rdy = m_ready();
      if (addr_we_i) m_addr = addr_wdata_i;
      if (pb_clr_i) m_idx = 0;
      else if (pb_valid_i && rdy) begin
        m_mem[m_idx / 4] = pb_data_i; m_idx += 4;
      end
    end
  end

  // every-cycle comparison at the falling edge
  always @(negedge clk) begin
    if (cmp_en) begin
      ent_t e;
      e = '{default: 0};
      if (q.size() != 0) e = q[0];
      chk("R5 busy", busy_o, q.size() != 0);
      chk("R9 addr", addr_o, m_addr);
      chk("R2 index", pb_idx_o, m_idx);
      chk("R3 ready", pb_ready_o, m_ready());
      chk("R4 prog strobe", mac_prog_o, e.p);
      chk("R6 page erase strobe", mac_erase_o, e.e);
      chk("R7 mass erase strobe", mac_erase_all_o, e.a);
      chk("R8 recall strobe", mac_recall_o, e.r);
      chk("R4 mac addr", mac_addr_o, e.ma);
      chk("R4 mac wdata", mac_wdata_o, e.wd);
    end
  end

  task automatic run_op(input logic [1:0] c);
    int guard = 0;
    @(negedge clk); cmd_i = c; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    while (busy_o && guard < 5000) begin @(negedge clk); guard++; end
  endtask

  task automatic push(input logic [31:0] d);
    @(negedge clk); pb_valid_i = 1'b1; pb_data_i = d;
    @(negedge clk); pb_valid_i = 1'b0;
  endtask

  task automatic set_addr(input logic [ADDR_W-1:0] a);
    @(negedge clk); addr_we_i = 1'b1; addr_wdata_i = a;
    @(negedge clk); addr_we_i = 1'b0;
  endtask

  task automatic clear_idx();
    @(negedge clk); pb_clr_i = 1'b1;
    @(negedge clk); pb_clr_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 50000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual %0d expected below 50000 cycles", cyc);
        finish_run();
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy_o, 0);
    chk("R1 addr", addr_o, 0);
    chk("R1 index", pb_idx_o, 0);
    chk("R1 strobes", {mac_prog_o, mac_erase_o, mac_erase_all_o, mac_recall_o}, 0);
    chk("R1 mac bus", {mac_addr_o, mac_wdata_o}, 0);
    rst_n = 1'b1;
    cmp_en = 1'b1;
    timing0_i = {16'd2, 16'h003F};
    timing1_i = 32'hFF00_0005;
    timing2_i = {4'hF, 4'h0, 8'd2, 16'd3};

    // R2 R4 three-word program burst
    set_addr(20'h00100);
    push(32'hA1A1_0001); push(32'hB2B2_0002); push(32'hC3C3_0003);
    chk("R2 index after three beats", pb_idx_o, 12);
    run_op(2'b00);
    chk("R9 address advanced by index", addr_o, 20'h0010C);
    chk("R9 index kept", pb_idx_o, 12);

    // R3 back-pressure at the aligned boundary: offset 12 leaves room for 5 words
    clear_idx();
    @(negedge clk); pb_valid_i = 1'b1;
    for (int i = 0; i < 8; i++) begin
      pb_data_i = 32'h5000_0000 + i;
      @(negedge clk);
    end
    pb_valid_i = 1'b0;
    chk("R3 index stopped at boundary", pb_idx_o, 20);
    run_op(2'b00);
    chk("R9 address after boundary burst", addr_o, 20'h00120);

    // R4 zero program count gives one cycle per word
    timing2_i[15:0] = 16'd0;
    clear_idx();
    push(32'h1111_2222); push(32'h3333_4444);
    run_op(2'b00);
    chk("R9 address after short burst", addr_o, 20'h00128);

    // R11 empty program
    clear_idx();
    run_op(2'b00);
    chk("R11 address unchanged", addr_o, 20'h00128);

    // R6 R10 page erase with inputs applied while busy
    set_addr(20'h01234);
    push(32'hDEAD_BEEF);
    @(negedge clk); cmd_i = 2'b01; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    @(negedge clk);
    start_i = 1'b1; cmd_i = 2'b11; addr_we_i = 1'b1; addr_wdata_i = 20'hFFFFF;
    pb_clr_i = 1'b1; pb_valid_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; addr_we_i = 1'b0; pb_clr_i = 1'b0; pb_valid_i = 1'b0;
    while (busy_o) @(negedge clk);
    chk("R10 index untouched while busy", pb_idx_o, 4);
    chk("R10 address only advanced by index", addr_o, 20'h01238);

    // R7 mass erase with no hold
    timing0_i[31:16] = 16'd0;
    clear_idx();
    run_op(2'b10);
    chk("R7 idle after mass erase", busy_o, 0);

    // R8 recall, zero and nonzero counts
    timing0_i[31:16] = 16'd3;
    timing2_i[23:16] = 8'd0;
    run_op(2'b11);
    timing2_i[23:16] = 8'd4;
    run_op(2'b11);
    chk("R8 address after recall", addr_o, 20'h01238);

    repeat (3) @(negedge clk);
    cmp_en = 1'b0;
    finish_run();
  end

endmodule